// File: doc/BRIEF.md
# Lock-Step Tagged Pipeline

This block carries data words through a fixed chain of combinational transforms separated by registers. Each register slot pairs a data word with a presence flag, so a cycle in which no input is available sends an empty slot (a bubble) down the chain instead of freezing it. A small input queue collects words from a valid/ready producer, and a small output queue hands finished words to a valid/ready consumer.

Every register slot, the removal from the input queue and the insertion into the output queue are decided together, once per clock. When the word leaving the last slot has nowhere to go because the output queue is full, the whole chain holds for that cycle. No slot has its own handshake. The transforms are simple constant operations, chosen so that results can be predicted exactly. Typical use is as a template for a deep arithmetic path whose throughput only drops when the consumer pushes back.

Top module: `lockstep_pipe`

## Requirements
- R1: When the input queue is non-empty and the chain is not held, its head word passes through transform 1, is written into the first slot marked present, and is removed from the input queue on the same clock edge.
- R2: When the input queue is empty and the chain is not held, the first slot is marked empty. Gaps in the input stream therefore reach the output as gaps of the same length.
- R3: When the chain is not held, each later slot takes the previous slot's word through its own transform, and takes the previous slot's presence flag.
- R4: When the last slot is present and the chain is not held, its word passes through the final transform NUM_STAGES and is written into the output queue. An empty last slot writes nothing.
- R5: Transform k (k = 1..NUM_STAGES) uses the constant K(k), which is the low DATA_W bits of (k * 0x9E3779B9 + 0x1357) mod 2^32. For odd k the result is x XOR K(k). For even k the result is (x + K(k)) mod 2^DATA_W.
- R6: The chain is held when the last slot is present and the output queue holds FIFO_DEPTH words at the start of the cycle, even if the consumer reads in that same cycle. While it is held, no slot changes and nothing leaves the input queue.
- R7: A synchronous active-high reset empties both queues and marks every slot empty. After reset, out_valid is 0 and in_ready is 1, and no word accepted before the reset ever reaches the output.
- R8: Words leave in the order they were accepted, each with all NUM_STAGES transforms applied. With no hold, a word accepted on clock edge e can be read on edge e+NUM_STAGES+1.
- R9: in_ready is 1 exactly when the input queue (FIFO_DEPTH entries) has space. With the consumer stopped, the block accepts NUM_STAGES-1+2*FIFO_DEPTH words and then drops in_ready.
- R10: While the consumer is stopped, out_valid stays 1 and out_data keeps showing the oldest unread result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers in_data |
| in_data | input | DATA_W | Word offered by the producer |
| in_ready | output | 1 | Input queue has space |
| out_valid | output | 1 | Output queue holds a result |
| out_data | output | DATA_W | Oldest unread result |
| out_ready | input | 1 | Consumer takes out_data this cycle |

## Verification
The bench builds the block with NUM_STAGES = 5 and DATA_W = 12, and keeps the default queue depth of 2. An odd stage count makes the final transform an XOR and places both kinds of transform in the middle of the chain. A 12-bit width exercises truncation of the 32-bit constants and wrap-around of the additions. With five stages the latency window of six edges and the stall capacity of eight words are large enough to separate every register on the path. A one-cycle read while the chain is full shows the conservative hold at the ports.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

    // Constants that generate the per-stage key
    localparam logic [31:0] KEY_MUL = 32'h9E37_79B9;
    localparam logic [31:0] KEY_ADD = 32'h0000_1357;

    typedef enum logic {
        XF_ADD = 1'b0,
        XF_XOR = 1'b1
    } xform_e;

    // Control decided once per clock for the whole chain
    typedef struct packed {
        logic advance;  // chain moves this cycle
        logic take;     // remove head of input queue
        logic emit;     // write final result into output queue
    } step_t;

    function automatic logic [31:0] stage_key(input int unsigned k);
        logic [31:0] kk;
        kk = k;
        return kk * KEY_MUL + KEY_ADD;
    endfunction

    function automatic xform_e stage_op(input int unsigned k);
        return (k % 2 == 1) ? XF_XOR : XF_ADD;
    endfunction

endpackage

// File: rtl/lockstep_xform.sv
module lockstep_xform #(
    parameter int          DATA_W = 16,
    parameter int unsigned STAGE  = 1
) (
    input  logic [DATA_W-1:0] x_in,
    output logic [DATA_W-1:0] x_out
);
    import lockstep_pkg::*;

    localparam logic [31:0]       KEY_FULL = stage_key(STAGE);
    localparam logic [DATA_W-1:0] KEY      = KEY_FULL[DATA_W-1:0];
    localparam xform_e            OP       = stage_op(STAGE);

    generate
        if (OP == XF_XOR) begin : g_xor
            assign x_out = x_in ^ KEY;
        end else begin : g_add
            assign x_out = x_in + KEY;
        end
    endgenerate

endmodule

// File: rtl/lockstep_fifo.sv
module lockstep_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2    // power of two, at least 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic              do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe #(
    parameter int DATA_W     = 16,
    parameter int NUM_STAGES = 4,   // at least 2
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    import lockstep_pkg::*;

    localparam int NREG = NUM_STAGES - 1;

    logic              in_full, in_empty, out_full, out_empty;
    logic [DATA_W-1:0] in_head;
    logic [NREG-1:0]   vld_q;
    logic [DATA_W-1:0] dat_q  [NREG];
    logic [DATA_W-1:0] xf_in  [NUM_STAGES];
    logic [DATA_W-1:0] xf_out [NUM_STAGES];
    step_t             step;

    // Input queue
    lockstep_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_q (
        .clk(clk), .rst(rst),
        .push(in_valid), .push_data(in_data),
        .pop(step.take), .head(in_head),
        .full(in_full), .empty(in_empty)
    );
    assign in_ready = !in_full;

    // One transform per stage; stage k reads the slot in front of it
    assign xf_in[0] = in_head;
    generate
        for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
            if (k > 0) begin : g_tap
                assign xf_in[k] = dat_q[k-1];
            end
            lockstep_xform #(.DATA_W(DATA_W), .STAGE(k + 1)) u_xf (
                .x_in(xf_in[k]), .x_out(xf_out[k])
            );
        end
    endgenerate

    // Global step: the full output condition holds the whole chain
    always_comb begin
        step.advance = !(vld_q[NREG-1] && out_full);
        step.take    = step.advance && !in_empty;
        step.emit    = step.advance && vld_q[NREG-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (step.advance) begin
            for (int j = NREG - 1; j > 0; j--) vld_q[j] <= vld_q[j-1];
            vld_q[0] <= !in_empty;
        end
    end

    always_ff @(posedge clk) begin
        if (step.advance) begin
            for (int j = 0; j < NREG; j++) dat_q[j] <= xf_out[j];
        end
    end

    // Output queue
    lockstep_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_q (
        .clk(clk), .rst(rst),
        .push(step.emit), .push_data(xf_out[NUM_STAGES-1]),
        .pop(out_ready), .head(out_data),
        .full(out_full), .empty(out_empty)
    );
    assign out_valid = !out_empty;

    // Checks beside the step logic
    AST_ENTRY_TAKES: assert property (@(posedge clk) disable iff (rst)
        (step.advance && !in_empty) |=> vld_q[0]);                         // R1
    AST_ENTRY_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (step.advance && in_empty) |=> !vld_q[0]);                         // R2
    AST_EMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (step.advance && vld_q[NREG-1]) |=> !out_empty);                   // R4
    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (vld_q[NREG-1] && out_full) |=> $stable(vld_q));                   // R6
    AST_HOLD_LAST: assert property (@(posedge clk) disable iff (rst)
        (vld_q[NREG-1] && out_full) |=> $stable(dat_q[NREG-1]));           // R6

    generate
        for (genvar j = 1; j < NREG; j++) begin : g_shift_chk
            AST_SHIFT_FLAG: assert property (@(posedge clk) disable iff (rst)
                step.advance |=> (vld_q[j] == $past(vld_q[j-1])));         // R3
        end
    endgenerate

endmodule

// File: tb/lockstep_pipe_bench.sv
module lockstep_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 12;
    localparam int N   = 5;
    localparam int DEP = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_ready = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [W-1:0] exp_q[$];
    int           in_cyc[$];
    logic [W-1:0] got_q[$];
    int           got_cyc[$];

    lockstep_pipe #(.DATA_W(W), .NUM_STAGES(N), .FIFO_DEPTH(DEP)) u_lockstep_pipe (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference transform from R5
    function automatic logic [W-1:0] ref_f(input int k, input logic [W-1:0] x);
        logic [31:0] key;
        key = 32'(k) * 32'h9E37_79B9 + 32'h1357;
        if (k % 2 == 1) return x ^ key[W-1:0];
        return x + key[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_chain(input logic [W-1:0] x);
        logic [W-1:0] v;
        v = x;
        for (int k = 1; k <= N; k++) v = ref_f(k, v);
        return v;
    endfunction

    // Handshake monitors, sampled at the edge on pre-edge values
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && in_valid && in_ready) begin
            exp_q.push_back(ref_chain(in_data));
            in_cyc.push_back(cyc);
        end
        if (!rst && out_valid && out_ready) begin
            got_q.push_back(out_data);
            got_cyc.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_queues();
        exp_q.delete(); in_cyc.delete(); got_q.delete(); got_cyc.delete();
    endtask

    task automatic send(input logic [W-1:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_outputs(input string req, input bit with_lat);
        for (int w = 0; w < 300 && got_q.size() < exp_q.size(); w++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            chk(got_q[i] == exp_q[i], req, int'(got_q[i]), int'(exp_q[i]));
            if (with_lat)
                chk(got_cyc[i] - in_cyc[i] == N + 1, {req, " R8 latency"},
                    got_cyc[i] - in_cyc[i], N + 1);
        end
        clear_queues();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R7 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_single();
        out_ready = 1'b1;
        send(12'h0A5);
        check_outputs("R1 R5 single word", 1'b1);
        send(12'hFFF);
        check_outputs("R5 wrap word", 1'b1);
    endtask

    task automatic t_stream();
        out_ready = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b1;
            in_data  = W'(i * 37 + 5);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check_outputs("R3 R8 back-to-back stream", 1'b1);
    endtask

    task automatic t_bubbles();
        out_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            send(W'(12'h700 + i * 3));
            repeat (i % 3) @(negedge clk);
        end
        // Gaps preserved: every word keeps the fixed latency
        check_outputs("R2 R4 gapped stream", 1'b1);
    endtask

    task automatic t_backpressure();
        logic [W-1:0] held;
        out_ready = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            in_valid = in_ready;
            in_data  = W'(12'h300 + i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(exp_q.size() == N - 1 + 2 * DEP, "R9 capacity", exp_q.size(), N - 1 + 2 * DEP);
        chk(in_ready == 1'b0, "R9 in_ready low when full", in_ready, 0);
        chk(out_valid == 1'b1, "R10 out_valid held", out_valid, 1);
        held = out_data;
        chk(held == exp_q[0], "R10 oldest result shown", int'(held), int'(exp_q[0]));
        repeat (4) @(negedge clk);
        chk(out_data == held, "R10 out_data stable", int'(out_data), int'(held));
        // One read while full: the chain still holds this cycle
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready == 1'b0, "R6 held despite same-cycle read", in_ready, 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R6 chain moves after read", in_ready, 1);
        out_ready = 1'b1;
        check_outputs("R6 R8 drain after stall", 1'b0);
    endtask

    task automatic t_reset_flush();
        out_ready = 1'b0;
        send(12'h111);
        send(12'h222);
        send(12'h333);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_queues();
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid after flush", out_valid, 0);
        chk(in_ready == 1'b1, "R7 in_ready after flush", in_ready, 1);
        repeat (15) @(negedge clk);
        chk(got_q.size() == 0, "R7 no stale output", got_q.size(), 0);
        clear_queues();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_stream();
        t_bubbles();
        t_backpressure();
        t_reset_flush();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule